// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

A bank of single-bit hardware semaphores shared between a left and a right port. The bank sits apart from any memory array. Each port claims a semaphore by writing a zero to it, then reads the same semaphore back. A zero means the port holds it. A one means the other side holds it. Writing a one gives a held semaphore back, or withdraws a claim that is still waiting.

The bank remembers one waiting claim per semaphore, from the side that does not hold it. When the holder gives the semaphore back, the waiting side takes it in that same clock cycle, with no further access needed. Each port sees the shared state from its own side: the holder reads zero and the other port reads one. Reads are registered. The captured value stays on the output until that port reads again, so a write by the other port cannot change it.

Top module: `sem_latch_pair`

## Requirements
- R1: The bank holds NUM_SEM (default 8) semaphores. The semaphore is chosen by the low three bits of the port address. All higher address bits have no effect.
- R2: A port makes an access only in a cycle where its select is 1 and its memory enable is 0. In any other cycle its write and read inputs change neither the semaphore state nor its read-data output.
- R3: After reset every semaphore is free, and both read-data buses hold all ones.
- R4: A write uses only data-in bit 0: 0 claims the semaphore and 1 releases it. A claim on a free semaphore makes the claiming port hold it: that port reads 0 and the other port reads 1.
- R5: At no time does a semaphore read as 0 on both ports.
- R6: A release by the holder with no claim waiting leaves the semaphore free, and both ports read 1.
- R7: A claim by the non-holder is stored as waiting. On the cycle the holder releases, the waiting side becomes holder. A claim written in the same cycle as the release also counts.
- R8: A release written by the non-holder only withdraws its waiting claim. The holder keeps the semaphore, and a later release by the holder leaves it free.
- R9: Claims on a free semaphore from both ports in the same cycle go to the left port. The right port's claim is kept as waiting.
- R10: A read puts the semaphore's state as seen by that port, before the clock edge, on every bit of its read-data bus. The bus changes one cycle after the read and holds its value until that port's next read, whatever the other port does.
- R11: A claim written by the current holder changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lSel | input | 1 | Left semaphore select, active high |
| lMemEn | input | 1 | Left memory enable; a semaphore access is blocked while it is 1 |
| lWe | input | 1 | Left write (1) or read (0) |
| lAddr | input | ADDR_W (14) | Left address; only the low three bits are used |
| lWdata | input | DATA_W (16) | Left write data; only bit 0 is used |
| lRdata | output | DATA_W (16) | Left registered read data |
| rSel | input | 1 | Right semaphore select, active high |
| rMemEn | input | 1 | Right memory enable; a semaphore access is blocked while it is 1 |
| rWe | input | 1 | Right write (1) or read (0) |
| rAddr | input | ADDR_W (14) | Right address; only the low three bits are used |
| rWdata | input | DATA_W (16) | Right write data; only bit 0 is used |
| rRdata | output | DATA_W (16) | Right registered read data |

## Verification
The assertions assume that every input settles between clock edges. They also assume that a port never reads and writes in the same cycle, which holds because a single write flag chooses between the two. The bench changes inputs only on falling edges. Each scenario drives one access per port per cycle and then returns both selects low. This lets the hold and idle properties see real quiet cycles between the directed claims, releases and reads.

// File: rtl/sem_latch_pkg.sv
package sem_latch_pkg;

  // Holder of one semaphore.
  typedef enum logic [1:0] {
    SEM_FREE  = 2'd0,
    SEM_LEFT  = 2'd1,
    SEM_RIGHT = 2'd2
  } semOwner_e;

  // Strobes from control to datapath, one set per port.
  typedef struct packed {
    logic rd;   // capture the semaphore view into the read register
    logic req;  // claim (data bit 0 written as 0)
    logic rel;  // release or withdraw (data bit 0 written as 1)
  } portStrobe_t;

  localparam int NUM_PORTS = 2;
  localparam int PORT_L    = 0;
  localparam int PORT_R    = 1;

endpackage

// File: rtl/sem_latch_ctrl.sv
module sem_latch_ctrl
  import sem_latch_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int SEM_AW = 3
) (
  input  logic [NUM_PORTS-1:0]             sel,
  input  logic [NUM_PORTS-1:0]             memEn,
  input  logic [NUM_PORTS-1:0]             we,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata,
  output portStrobe_t [NUM_PORTS-1:0]      strobe,
  output logic [NUM_PORTS-1:0][SEM_AW-1:0] semIdx
);

  logic [NUM_PORTS-1:0] active;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic unusedHigh;

    assign active[p]     = sel[p] & ~memEn[p];
    assign strobe[p].rd  = active[p] & ~we[p];
    assign strobe[p].req = active[p] &  we[p] & ~wdata[p][0];
    assign strobe[p].rel = active[p] &  we[p] &  wdata[p][0];
    assign semIdx[p]     = addr[p][SEM_AW-1:0];

    // Address bits above the semaphore index and data bits above bit 0 have no effect.
    assign unusedHigh = ^{addr[p][ADDR_W-1:SEM_AW], wdata[p][DATA_W-1:1]};
  end

endmodule

// File: rtl/sem_latch_cell.sv
module sem_latch_cell
  import sem_latch_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqL,
  input  logic relL,
  input  logic reqR,
  input  logic relR,
  output logic viewL,
  output logic viewR
);

  semOwner_e owner, ownerNext;
  logic      waiting, waitingNext;   // claim held for the non-owner

  always_comb begin
    ownerNext   = owner;
    waitingNext = waiting;
    unique case (owner)
      SEM_FREE: begin
        if (reqL) begin
          ownerNext   = SEM_LEFT;
          waitingNext = reqR;
        end else if (reqR) begin
          ownerNext   = SEM_RIGHT;
          waitingNext = 1'b0;
        end
      end
      SEM_LEFT: begin
        if (relL) begin
          ownerNext   = ((waiting && !relR) || reqR) ? SEM_RIGHT : SEM_FREE;
          waitingNext = 1'b0;
        end else if (reqR) begin
          waitingNext = 1'b1;
        end else if (relR) begin
          waitingNext = 1'b0;
        end
      end
      SEM_RIGHT: begin
        if (relR) begin
          ownerNext   = ((waiting && !relL) || reqL) ? SEM_LEFT : SEM_FREE;
          waitingNext = 1'b0;
        end else if (reqL) begin
          waitingNext = 1'b1;
        end else if (relL) begin
          waitingNext = 1'b0;
        end
      end
      default: begin
        ownerNext   = SEM_FREE;
        waitingNext = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owner   <= SEM_FREE;
      waiting <= 1'b0;
    end else begin
      owner   <= ownerNext;
      waiting <= waitingNext;
    end
  end

  assign viewL = (owner != SEM_LEFT);
  assign viewR = (owner != SEM_RIGHT);

endmodule

// File: rtl/sem_latch_datapath.sv
module sem_latch_datapath
  import sem_latch_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  parameter int SEM_AW  = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  portStrobe_t [NUM_PORTS-1:0]      strobe,
  input  logic [NUM_PORTS-1:0][SEM_AW-1:0] semIdx,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rdata,
  output logic [NUM_SEM-1:0]               viewL,
  output logic [NUM_SEM-1:0]               viewR
);

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    logic hitL, hitR;
    assign hitL = (semIdx[PORT_L] == SEM_AW'(i));
    assign hitR = (semIdx[PORT_R] == SEM_AW'(i));

    sem_latch_cell u_cell (
      .clk   (clk),
      .rstN  (rstN),
      .reqL  (strobe[PORT_L].req & hitL),
      .relL  (strobe[PORT_L].rel & hitL),
      .reqR  (strobe[PORT_R].req & hitR),
      .relR  (strobe[PORT_R].rel & hitR),
      .viewL (viewL[i]),
      .viewR (viewR[i])
    );
  end

  logic [NUM_PORTS-1:0][NUM_SEM-1:0] portView;
  assign portView[PORT_L] = viewL;
  assign portView[PORT_R] = viewR;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_read
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdata[p] <= '1;
      end else if (strobe[p].rd) begin
        rdata[p] <= {DATA_W{portView[p][semIdx[p]]}};
      end
    end
  end

endmodule

// File: rtl/sem_latch_pair.sv
module sem_latch_pair
  import sem_latch_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lSel,
  input  logic              lMemEn,
  input  logic              lWe,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  input  logic              rSel,
  input  logic              rMemEn,
  input  logic              rWe,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata
);

  localparam int SEM_AW = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

  portStrobe_t [NUM_PORTS-1:0]      strobe;
  logic [NUM_PORTS-1:0][SEM_AW-1:0] semIdx;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rdata;
  logic [NUM_SEM-1:0]               viewL, viewR;

  sem_latch_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEM_AW (SEM_AW)
  ) u_ctrl (
    .sel    ({rSel, lSel}),
    .memEn  ({rMemEn, lMemEn}),
    .we     ({rWe, lWe}),
    .addr   ({rAddr, lAddr}),
    .wdata  ({rWdata, lWdata}),
    .strobe (strobe),
    .semIdx (semIdx)
  );

  sem_latch_datapath #(
    .NUM_SEM (NUM_SEM),
    .DATA_W  (DATA_W),
    .SEM_AW  (SEM_AW)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .semIdx (semIdx),
    .rdata  (rdata),
    .viewL  (viewL),
    .viewR  (viewR)
  );

  assign lRdata = rdata[PORT_L];
  assign rRdata = rdata[PORT_R];

endmodule

// File: rtl/sem_latch_pair_chk.sv
module sem_latch_pair_chk #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              lSel,
  input logic              lMemEn,
  input logic              lWe,
  input logic [DATA_W-1:0] lRdata,
  input logic              rSel,
  input logic              rMemEn,
  input logic              rWe,
  input logic [DATA_W-1:0] rRdata,
  input logic [NUM_SEM-1:0] viewL,
  input logic [NUM_SEM-1:0] viewR
);

  logic lAct, rAct;
  assign lAct = lSel & ~lMemEn;
  assign rAct = rSel & ~rMemEn;

  // R5: never held by both sides
  a_r5_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    (~viewL & ~viewR) == '0);

  // R10: every read-data bit carries the same value
  a_r10_uniform_left: assert property (@(posedge clk) disable iff (!rstN)
    (lRdata == '0) || (lRdata == '1));
  a_r10_uniform_right: assert property (@(posedge clk) disable iff (!rstN)
    (rRdata == '0) || (rRdata == '1));

  // R10: without a read by that port its output holds
  a_r10_hold_left: assert property (@(posedge clk) disable iff (!rstN)
    !(lAct && !lWe) |=> $stable(lRdata));
  a_r10_hold_right: assert property (@(posedge clk) disable iff (!rstN)
    !(rAct && !rWe) |=> $stable(rRdata));

  // R2: with no access on either port the shared state is unchanged
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!lAct && !rAct) |=> ($stable(viewL) && $stable(viewR)));

  // R8: a holder keeps its semaphores until it writes
  a_r8_left_keeps: assert property (@(posedge clk) disable iff (!rstN)
    !(lAct && lWe) |=> ((viewL & ~$past(viewL)) == '0));
  a_r8_right_keeps: assert property (@(posedge clk) disable iff (!rstN)
    !(rAct && rWe) |=> ((viewR & ~$past(viewR)) == '0));

endmodule

bind sem_latch_pair sem_latch_pair_chk #(
  .NUM_SEM (NUM_SEM),
  .DATA_W  (DATA_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .lSel   (lSel),
  .lMemEn (lMemEn),
  .lWe    (lWe),
  .lRdata (lRdata),
  .rSel   (rSel),
  .rMemEn (rMemEn),
  .rWe    (rWe),
  .rRdata (rRdata),
  .viewL  (viewL),
  .viewR  (viewR)
);

// File: tb/sem_latch_pair_bench.sv
module sem_latch_pair_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lSel = 0, lMemEn = 0, lWe = 0, rSel = 0, rMemEn = 0, rWe = 0;
  logic [13:0] lAddr = '0, rAddr = '0;
  logic [15:0] lWdata = '0, rWdata = '0;
  logic [15:0] lRdata, rRdata;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sem_latch_pair u_sem_latch_pair (
    .clk(clk), .rstN(rstN),
    .lSel(lSel), .lMemEn(lMemEn), .lWe(lWe), .lAddr(lAddr), .lWdata(lWdata), .lRdata(lRdata),
    .rSel(rSel), .rMemEn(rMemEn), .rWe(rWe), .rAddr(rAddr), .rWdata(rWdata), .rRdata(rRdata)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle: both ports driven at a falling edge, released at the next one.
  task automatic cyc(input logic lS, input logic lW, input logic [13:0] lA, input logic [15:0] lD,
                     input logic rS, input logic rW, input logic [13:0] rA, input logic [15:0] rD);
    @(negedge clk);
    lSel = lS; lWe = lW; lAddr = lA; lWdata = lD;
    rSel = rS; rWe = rW; rAddr = rA; rWdata = rD;
    @(negedge clk);
    lSel = 0; lWe = 0; rSel = 0; rWe = 0;
  endtask

  task automatic lWr(input logic [13:0] a, input logic [15:0] d); cyc(1, 1, a, d, 0, 0, 0, 0); endtask
  task automatic rWr(input logic [13:0] a, input logic [15:0] d); cyc(0, 0, 0, 0, 1, 1, a, d); endtask

  // Read one index on both ports in the same cycle and compare.
  task automatic rdBoth(input string tag, input logic [13:0] a, input logic lExp, input logic rExp);
    cyc(1, 0, a, 0, 1, 0, a, 0);
    chk({tag, " left"},  lRdata, {16{lExp}});
    chk({tag, " right"}, rRdata, {16{rExp}});
  endtask

  task automatic t_reset();
    chk("R3 reset left bus", lRdata, 16'hFFFF);
    chk("R3 reset right bus", rRdata, 16'hFFFF);
    for (int i = 0; i < 8; i++) rdBoth("R3 free after reset", 14'(i), 1, 1);
  endtask

  task automatic t_grant();
    lWr(14'h3FFA, 16'h0000);            // R1: high bits set, index 2
    rdBoth("R1 R4 grant idx2", 14'h0002, 0, 1);
    rdBoth("R1 neighbour idx3", 14'h0003, 1, 1);
    lWr(14'h0002, 16'h0000);            // R11: holder claims again
    rdBoth("R11 reclaim", 14'h0002, 0, 1);
  endtask

  task automatic t_bit0();
    rWr(14'h0005, 16'hFFFE);            // R4: only bit 0 counts -> claim
    rdBoth("R4 bit0 claim", 14'h0005, 1, 0);
    rWr(14'h0005, 16'h0001);
    rdBoth("R6 release free", 14'h0005, 1, 1);
  endtask

  task automatic t_handover();
    rWr(14'h0002, 16'h0001);            // non-holder release, nothing waiting
    rdBoth("R8 nonholder release", 14'h0002, 0, 1);
    rWr(14'h0002, 16'h0000);            // waiting claim
    rdBoth("R5 R7 waiting", 14'h0002, 0, 1);
    lWr(14'h0002, 16'h0001);
    rdBoth("R7 handover", 14'h0002, 1, 0);
    rWr(14'h0002, 16'h0001);
    rdBoth("R6 free again", 14'h0002, 1, 1);
    // claim written in the same cycle as the release
    lWr(14'h0000, 16'h0000);
    cyc(1, 1, 14'h0000, 16'h0001, 1, 1, 14'h0000, 16'h0000);
    rdBoth("R7 same cycle claim", 14'h0000, 1, 0);
    rWr(14'h0000, 16'h0001);
  endtask

  task automatic t_cancel();
    lWr(14'h0004, 16'h0000);
    rWr(14'h0004, 16'h0000);
    rWr(14'h0004, 16'h0001);            // withdraw
    rdBoth("R8 withdraw keeps holder", 14'h0004, 0, 1);
    lWr(14'h0004, 16'h0001);
    rdBoth("R8 free after withdraw", 14'h0004, 1, 1);
  endtask

  task automatic t_tie();
    cyc(1, 1, 14'h0006, 16'h0000, 1, 1, 14'h0006, 16'h0000);
    rdBoth("R9 left wins tie", 14'h0006, 0, 1);
    lWr(14'h0006, 16'h0001);
    rdBoth("R9 right kept waiting", 14'h0006, 1, 0);
    rWr(14'h0006, 16'h0001);
  endtask

  task automatic t_blocked();
    lMemEn = 1;
    lWr(14'h0001, 16'h0000);            // blocked by memory enable
    lMemEn = 0;
    cyc(0, 1, 14'h0001, 16'h0000, 0, 1, 14'h0001, 16'h0000);   // select low
    rdBoth("R2 blocked writes", 14'h0001, 1, 1);
    rWr(14'h0001, 16'h0000);
    rMemEn = 1;
    cyc(0, 0, 0, 0, 1, 0, 14'h0001, 0); // blocked read leaves bus alone
    rMemEn = 0;
    chk("R2 blocked read bus", rRdata, 16'hFFFF);
    rWr(14'h0001, 16'h0001);
  endtask

  task automatic t_latch();
    // left reads idx7 in the same cycle the right claims it
    cyc(1, 0, 14'h0007, 0, 1, 1, 14'h0007, 16'h0000);
    chk("R10 pre-edge value", lRdata, 16'hFFFF);
    rWr(14'h0007, 16'h0001);
    rWr(14'h0007, 16'h0000);
    chk("R10 held across writes", lRdata, 16'hFFFF);
    cyc(0, 0, 0, 0, 1, 0, 14'h0007, 0);
    chk("R10 right reads held", rRdata, 16'h0000);
    lWr(14'h0007, 16'h0000);
    rWr(14'h0007, 16'h0001);
    rdBoth("R7 R10 left takes idx7", 14'h0007, 0, 1);
    lWr(14'h0007, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_grant();
    t_bit0();
    t_handover();
    t_cancel();
    t_tie();
    t_blocked();
    t_latch();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule